// File: doc/BRIEF.md
# Address Decoder with Phase-2 Clock Stretching

This block is the glue logic between an 8-bit CPU, two 32 KiB static RAM banks and a slow bus that carries ROM and I/O. It splits the 16-bit address space into a low RAM bank, a high RAM bank and a slow region. It drives the RAM enables and the direction of the data transceiver. It also sends buffered copies of A8 and the read/write line to the I/O bus, and drives the upper I/O-bus address lines from the slow-region decode.

The CPU's phase-2 clock is the free-running oscillator clock ORed with a stretch flag. When the address in a cycle falls in the slow region, the flag is set on the rising edge of the oscillator clock. This holds phase 2 high through the low half-periods that follow, until the slow device raises its completion input. That input is first passed through a synchronizer, and its rising edge releases the flag. The flag changes only on rising oscillator edges, so phase 2 never shows a shortened low pulse or a runt high pulse.

A mode input lets the CPU vectors come from RAM. In this mode only the I/O window is slow, and the rest of the space above 8000h is served by the high RAM bank without stretching.

Top module: `busglue_stretch`

## Requirements
- R1: While rst_n is low (active-low, asynchronous) the stretch flag is clear, so phi2 equals clk: low in every low half-period and high in every high half-period.
- R2: ram_lo_en (active high) is 1 exactly when addr[15] is 0, in both modes.
- R3: With vec_ram=0, ram_hi_en (active high) is 1 for 8000h–FDFFh and 0 for FE00h–FFFFh and for the lower half.
- R4: With vec_ram=0, slow_sel is 1 exactly when addr[15:9] are all ones (FE00h–FFFFh). Every bit of xa_hi equals slow_sel.
- R5: With vec_ram=1, slow_sel is 1 only for FF00h–FFBFh. Every other address from 8000h up selects the high bank, and no stretch happens for those addresses.
- R6: phi2 = clk OR stretch. If slow_sel is 1 at a rising clk edge while no stretch is in progress, the flag sets at that edge. phi2 then stays high through the next low half-period, and the preceding low half-period is not shortened.
- R7: If io_done is high at rising clk edge k during a stretch and was low before, the flag clears at edge k+SYNC_STAGES (default 2). phi2 first falls at the falling edge after that. With io_done driven just before edge k, phi2 is therefore high in the three low half-periods starting with the one before k, and low in the fourth.
- R8: Only a rising edge of io_done releases a stretch. A rise while no stretch is in progress is ignored, and io_done held high does not end a later stretch.
- R9: rw is 1 for read and 0 for write. ram_oe = rw AND (either RAM bank enabled). ram_we = phi2 AND NOT rw AND (either RAM bank enabled).
- R10: io_rd = slow_sel AND rw. It turns the data transceiver toward the CPU.
- R11: xa8 equals addr[8] and xrw equals rw at all times.
- R12: Back-to-back slow cycles are each stretched. A slow address presented after a release sets the flag again at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock (unstretched) |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | CPU address bus |
| rw | input | 1 | CPU read/write, 1 = read |
| vec_ram | input | 1 | Mode: serve everything above 8000h except the I/O window from RAM |
| io_done | input | 1 | Slow device finished its access (asynchronous level) |
| phi2 | output | 1 | CPU phase-2 clock |
| ram_lo_en | output | 1 | Low RAM bank select, active high |
| ram_hi_en | output | 1 | High RAM bank select, active high |
| ram_oe | output | 1 | RAM output enable, active high |
| ram_we | output | 1 | RAM write enable, active high |
| slow_sel | output | 1 | Access is on the slow bus (ROM/I/O) |
| io_rd | output | 1 | Slow-bus read: transceiver toward the CPU |
| xa8 | output | 1 | Buffered copy of addr[8] |
| xrw | output | 1 | Buffered copy of rw |
| xa_hi | output | 7 | Upper I/O-bus address lines, each equal to slow_sel |

## Verification
The assertions check on every cycle that the stretch flag only rises after a slow request, only falls after a completion edge, and holds otherwise. They also check that it never rises from a RAM cycle, that the three selects are mutually exclusive, and that the high bank is never enabled in the top page in normal mode. Only the bench scenarios can show the exact release latency after io_done, the phase at which phi2 falls, and that a held io_done does not cut a later stretch short. The same holds for back-to-back slow cycles and for the full address table in both modes.

// File: rtl/bgs_pkg.sv
package bgs_pkg;
  localparam int ADDR_W     = 16;
  localparam int BANK_BIT   = ADDR_W - 1;
  localparam int SLOW_LSB   = 9;
  localparam int PAGE_LSB   = 8;
  localparam int XHI_W_DEF  = ADDR_W - SLOW_LSB;

  typedef enum logic [1:0] {
    REG_LO   = 2'd0,
    REG_HI   = 2'd1,
    REG_SLOW = 2'd2
  } region_t;

  // top 512 bytes: every bit from BANK_BIT down to SLOW_LSB set
  function automatic logic in_top_page(input logic [ADDR_W-1:0] a);
    return &a[BANK_BIT:SLOW_LSB];
  endfunction

  // I/O window: last 256-byte page minus its top quarter
  function automatic logic in_io_window(input logic [ADDR_W-1:0] a);
    return (&a[BANK_BIT:PAGE_LSB]) && (a[PAGE_LSB-1:PAGE_LSB-2] != 2'b11);
  endfunction

  function automatic region_t classify(input logic [ADDR_W-1:0] a, input logic vec_mode);
    logic slow;
    slow = vec_mode ? in_io_window(a) : in_top_page(a);
    if (!a[BANK_BIT]) return REG_LO;
    if (slow)         return REG_SLOW;
    return REG_HI;
  endfunction
endpackage

// File: rtl/addr_decode.sv
module addr_decode
  import bgs_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              rw,
  input  logic              vec_ram,
  output logic              lo_en,
  output logic              hi_en,
  output logic              slow,
  output logic              ram_any,
  output logic              oe_ram,
  output logic              io_rd
);
  region_t region;

  always_comb begin
    region  = classify(addr, vec_ram);
    lo_en   = (region == REG_LO);
    hi_en   = (region == REG_HI);
    slow    = (region == REG_SLOW);
    ram_any = lo_en | hi_en;
    oe_ram  = ram_any & rw;
    io_rd   = slow & rw;
  end
endmodule

// File: rtl/done_sync.sv
module done_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic d_sync
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d_async;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_async};
      end
    end
  endgenerate

  assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/stretch_ctl.sv
module stretch_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic slow_req,
  input  logic done_s,
  output logic stretch_q,
  output logic done_evt
);
  logic done_prev;

  assign done_evt = done_s & ~done_prev;

  // all changes happen on the rising oscillator edge: setting there keeps
  // phase 1 full length, clearing there lands inside a high half-period
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stretch_q <= 1'b0;
      done_prev <= 1'b0;
    end else begin
      done_prev <= done_s;
      if (stretch_q) begin
        if (done_evt) stretch_q <= 1'b0;
      end else if (slow_req) begin
        stretch_q <= 1'b1;
      end
    end
  end

  // R6: the flag only rises after a slow request
  a_r6_set_from_slow: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stretch_q) |-> $past(slow_req));
  // R7: the flag only falls after a completion edge
  a_r7_release_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stretch_q) |-> $past(done_evt));
  // R8: without a completion edge, a stretch persists
  a_r8_hold_without_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (stretch_q && !done_evt) |=> stretch_q);
  // R5: a non-slow cycle never starts a stretch
  a_r5_idle_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!stretch_q && !slow_req) |=> !stretch_q);
endmodule

// File: rtl/busglue_stretch.sv
module busglue_stretch
  import bgs_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int XHI_W       = XHI_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rw,
  input  logic              vec_ram,
  input  logic              io_done,
  output logic              phi2,
  output logic              ram_lo_en,
  output logic              ram_hi_en,
  output logic              ram_oe,
  output logic              ram_we,
  output logic              slow_sel,
  output logic              io_rd,
  output logic              xa8,
  output logic              xrw,
  output logic [XHI_W-1:0]  xa_hi
);
  logic ram_any;
  logic done_s;
  logic stretch;
  logic done_evt;

  addr_decode u_dec (
    .addr    (addr),
    .rw      (rw),
    .vec_ram (vec_ram),
    .lo_en   (ram_lo_en),
    .hi_en   (ram_hi_en),
    .slow    (slow_sel),
    .ram_any (ram_any),
    .oe_ram  (ram_oe),
    .io_rd   (io_rd)
  );

  done_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (io_done),
    .d_sync  (done_s)
  );

  stretch_ctl u_str (
    .clk       (clk),
    .rst_n     (rst_n),
    .slow_req  (slow_sel),
    .done_s    (done_s),
    .stretch_q (stretch),
    .done_evt  (done_evt)
  );

  assign phi2   = clk | stretch;
  assign ram_we = phi2 & ~rw & ram_any;
  assign xa8    = addr[PAGE_LSB];
  assign xrw    = rw;
  assign xa_hi  = {XHI_W{slow_sel}};

  // R4: selects are mutually exclusive
  a_r4_selects_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_lo_en, ram_hi_en, slow_sel}));
  // R3: high bank is never enabled in the top page in normal mode
  a_r3_no_hi_in_top_page: assert property (@(posedge clk) disable iff (!rst_n)
    (!vec_ram && (&addr[ADDR_W-1:ADDR_W-XHI_W])) |-> !ram_hi_en);
  // R10: a transceiver turn-around only happens for slow reads
  a_r10_iord_slow_read: assert property (@(posedge clk) disable iff (!rst_n)
    io_rd |-> (slow_sel && rw));
endmodule

// File: tb/busglue_stretch_test.sv
`timescale 1ns/1ps
module busglue_stretch_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic        rw = 1'b1;
  logic        vec_ram = 1'b0;
  logic        io_done = 1'b0;
  logic        phi2, ram_lo_en, ram_hi_en, ram_oe, ram_we, slow_sel, io_rd, xa8, xrw;
  logic [6:0]  xa_hi;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  busglue_stretch uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rw(rw), .vec_ram(vec_ram),
    .io_done(io_done), .phi2(phi2), .ram_lo_en(ram_lo_en), .ram_hi_en(ram_hi_en),
    .ram_oe(ram_oe), .ram_we(ram_we), .slow_sel(slow_sel), .io_rd(io_rd),
    .xa8(xa8), .xrw(xrw), .xa_hi(xa_hi)
  );

  // {iord, oe, slow, hi, lo, vec, rw, addr}
  localparam int NV = 15;
  localparam logic [22:0] VEC [NV] = '{
    {5'b01001, 2'b01, 16'h0000},
    {5'b00001, 2'b00, 16'h7FFF},
    {5'b01010, 2'b01, 16'h8000},
    {5'b01010, 2'b01, 16'hFDFF},
    {5'b10100, 2'b01, 16'hFE00},
    {5'b00100, 2'b00, 16'hFF50},
    {5'b10100, 2'b01, 16'hFFBF},
    {5'b10100, 2'b01, 16'hFFC0},
    {5'b10100, 2'b01, 16'hFFFF},
    {5'b01010, 2'b11, 16'hFE80},
    {5'b10100, 2'b11, 16'hFF00},
    {5'b10100, 2'b11, 16'hFFBF},
    {5'b01010, 2'b11, 16'hFFFC},
    {5'b00010, 2'b10, 16'hFFC0},
    {5'b01001, 2'b11, 16'h3000}
  };

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // low half-period sample point of the next cycle
  task automatic to_low();
    @(negedge clk); #1;
  endtask

  task automatic release_stretch();
    @(negedge clk);
    addr <= 16'h0100; rw <= 1'b1; io_done <= 1'b1;
    repeat (4) @(negedge clk);
    io_done <= 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1 reset: phi2 follows clk
    to_low();
    chk(phi2 == 1'b0, "R1 reset low phase", phi2, 0);
    @(posedge clk); #1;
    chk(phi2 == 1'b1, "R1 reset high phase", phi2, 1);
    @(negedge clk); rst_n <= 1'b1;
    repeat (2) @(negedge clk);

    // table walk: R2 R3 R4 R5 R9 R10 R11
    for (int i = 0; i < NV; i++) begin
      logic [22:0] v;
      logic e_lo, e_hi, e_sl, e_oe, e_rd;
      v = VEC[i];
      @(negedge clk);
      addr <= v[15:0]; rw <= v[16]; vec_ram <= v[17];
      e_lo = v[18]; e_hi = v[19]; e_sl = v[20]; e_oe = v[21]; e_rd = v[22];
      #1;
      chk(ram_lo_en == e_lo, $sformatf("R2 lo_en @%h", v[15:0]), ram_lo_en, e_lo);
      chk(ram_hi_en == e_hi, $sformatf("R3/R5 hi_en @%h", v[15:0]), ram_hi_en, e_hi);
      chk(slow_sel == e_sl && xa_hi == {7{e_sl}}, $sformatf("R4/R5 slow @%h", v[15:0]),
          {xa_hi, slow_sel}, {{7{e_sl}}, e_sl});
      chk(ram_oe == e_oe, $sformatf("R9 oe @%h", v[15:0]), ram_oe, e_oe);
      chk(io_rd == e_rd, $sformatf("R10 io_rd @%h", v[15:0]), io_rd, e_rd);
      chk(xa8 == v[8] && xrw == v[16], "R11 buffered copies", {xa8, xrw}, {v[8], v[16]});
      chk(ram_we == 1'b0, "R9 we low in phase 1", ram_we, 0);
      @(posedge clk); #1;
      chk(ram_we == ((e_lo | e_hi) & ~v[16]), $sformatf("R9 we @%h", v[15:0]),
          ram_we, (e_lo | e_hi) & ~v[16]);
      @(negedge clk); #1;
      chk(phi2 == e_sl, $sformatf("R6/R5 stretch @%h", v[15:0]), phi2, e_sl);
      if (e_sl) release_stretch();
    end
    vec_ram <= 1'b0;

    // R6/R7: exact stretch and release timing
    @(negedge clk); addr <= 16'hFF10; rw <= 1'b1;
    #1; chk(phi2 == 1'b0, "R6 phase 1 not shortened", phi2, 0);
    @(negedge clk); io_done <= 1'b1;
    #1; chk(phi2 == 1'b1, "R6 held high 1", phi2, 1);
    to_low(); chk(phi2 == 1'b1, "R7 held high 2", phi2, 1);
    @(posedge clk); #1; chk(phi2 == 1'b1, "R7 no runt at release edge", phi2, 1);
    to_low(); chk(phi2 == 1'b1, "R7 held high 3", phi2, 1);
    @(negedge clk);
    // R12: back-to-back slow access
    addr <= 16'hFE20; io_done <= 1'b0;
    #1; chk(phi2 == 1'b0, "R7 released low phase", phi2, 0);
    to_low(); chk(phi2 == 1'b1, "R12 second stretch", phi2, 1);
    release_stretch();
    to_low(); chk(phi2 == 1'b0, "R12 idle after release", phi2, 0);

    // R8: done rising while idle is ignored; held done does not release
    @(negedge clk); io_done <= 1'b1;
    repeat (4) @(negedge clk);
    addr <= 16'hFFD0;
    for (int j = 0; j < 5; j++) begin
      to_low(); chk(phi2 == 1'b1, "R8 held done keeps stretch", phi2, 1);
    end
    @(negedge clk); io_done <= 1'b0;
    repeat (2) @(negedge clk);
    io_done <= 1'b1;
    #1; chk(phi2 == 1'b1, "R8 before fresh edge", phi2, 1);
    to_low(); to_low();
    chk(phi2 == 1'b1, "R8 latency last high", phi2, 1);
    @(negedge clk); addr <= 16'h0200; io_done <= 1'b0;
    #1; chk(phi2 == 1'b0, "R8 fresh edge releases", phi2, 0);

    // R5: vector fetch from RAM in vec mode, no stretch
    @(negedge clk); vec_ram <= 1'b1; addr <= 16'hFFFA;
    to_low(); chk(phi2 == 1'b0, "R5 vector read not stretched", phi2, 0);
    @(negedge clk); vec_ram <= 1'b0; addr <= 16'h0000;

    // R1: asynchronous reset ends a stretch
    @(negedge clk); addr <= 16'hFF80;
    to_low(); chk(phi2 == 1'b1, "R6 stretch before reset", phi2, 1);
    rst_n <= 1'b0; addr <= 16'h0000;
    #0.5; chk(phi2 == 1'b0, "R1 reset clears stretch", phi2, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule